// File: doc/BRIEF.md
# Programmable RGB Channel Sequencer

This block steers a shared converter between three colour sampling channels (Red, Green, Blue). It does not process the analog signals. It watches three slow timing inputs as plain data: a line/pixel strobe, a sampling strobe and the converter clock. A fast system clock samples them, and the block turns their falling edges into channel-select decisions. The output is a 2-bit channel code and a matching one-hot enable.

Each falling edge of the sampling strobe steps the selection one channel along a rotation. A configuration bit chooses the direction of that rotation. Each falling edge of the pixel strobe returns the selection to the first channel of the chosen rotation. That same edge is the only point where a new direction is adopted. In the sample-and-hold sensor arrangement the sampling strobe stays low, so the selection stays on the first channel.

The block also checks when the switching edges arrive. A sampling-strobe fall seen while the converter clock is high sets a sticky error flag, and only an explicit clear pulse removes it.

This block has no data stream: all of its pins are plain control or status levels, so no valid/ready handshake and no back-pressure apply.

Top module: `rgb_seq_ctrl`

## Requirements
- R1: `chan_sel` always holds one of three codes: 0 = Red, 1 = Green, 2 = Blue. `chan_en` is one-hot, with bit 0 = Red, bit 1 = Green and bit 2 = Blue, and its set bit matches `chan_sel`.
- R2: After reset, `chan_sel` is 0 (Red), `chan_en` is 3'b001, `timing_err` is 0, and the active rotation is ascending.
- R3: While the active rotation is ascending (order bit 0), each `smp_clk_in` fall moves the selection Red to Green, Green to Blue and Blue back to Red.
- R4: While the active rotation is descending (order bit 1), each `smp_clk_in` fall moves the selection Blue to Green, Green to Red and Red back to Blue.
- R5: A `pix_clk_in` fall sets the selection to the first channel of the order given by `order_desc` at that edge: Red when the bit is 0, Blue when it is 1.
- R6: A change of `order_desc` does not alter the rotation until the next `pix_clk_in` fall. Sampling-strobe falls before that edge keep stepping in the previously active direction.
- R7: When falls of `pix_clk_in` and `smp_clk_in` are detected in the same system-clock cycle, the pixel-strobe reset wins. The selection becomes the first channel and does not step.
- R8: A `smp_clk_in` fall detected while `cnv_clk_in` is high sets `timing_err`. A fall detected while `cnv_clk_in` is low leaves it clear.
- R9: `timing_err` stays set until `err_clr` is pulsed high, and then it returns to 0.
- R10: With `smp_clk_in` held low (sample-and-hold mode), repeated `pix_clk_in` falls keep the selection on the first channel of the current order.
- R11: Every timing input passes through SYNC_STAGES flops. A fall applied between system-clock edges changes the outputs after exactly SYNC_STAGES+1 rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that oversamples the timing inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_clk_in | input | 1 | Pixel/line strobe; its fall restarts the rotation |
| smp_clk_in | input | 1 | Sampling strobe; its fall steps the rotation |
| cnv_clk_in | input | 1 | Converter clock; a step while it is high is a violation |
| order_desc | input | 1 | Rotation direction: 0 ascending (R,G,B), 1 descending (B,G,R) |
| err_clr | input | 1 | Pulse high to clear the timing error flag |
| chan_sel | output | 2 | Selected channel code (0 R, 1 G, 2 B) |
| chan_en | output | 3 | One-hot channel enable matching chan_sel |
| timing_err | output | 1 | Sticky edge-placement violation flag |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. It derives its exact latency check from a bench localparam of the same value, so the edge on which the selection must change is known in advance. Because the timing inputs change only well apart from the fast clock edges, every rotation step, wrap and reset is observed one at a time. The bench also drives the pixel and sampling strobes to fall in the same cycle, which exercises the priority between them. The converter clock is held at a fixed level during each stepping event, so both outcomes of the placement check can be produced on demand.

// File: rtl/rgb_seq_pkg.sv
package rgb_seq_pkg;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2
  } chan_e;

  // First channel of a rotation: Red when ascending, Blue when descending
  function automatic chan_e first_chan(input logic desc);
    return desc ? CH_BLUE : CH_RED;
  endfunction

  // Successor of a channel in the given rotation, wrapping after the third
  function automatic chan_e next_chan(input chan_e cur, input logic desc);
    chan_e nxt;
    if (!desc) begin
      case (cur)
        CH_RED:   nxt = CH_GREEN;
        CH_GREEN: nxt = CH_BLUE;
        default:  nxt = CH_RED;
      endcase
    end else begin
      case (cur)
        CH_BLUE:  nxt = CH_GREEN;
        CH_GREEN: nxt = CH_RED;
        default:  nxt = CH_BLUE;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= raw_in;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~chain[STAGES-1];

  // R11
  fall_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> ($past(chain[STAGES-1]) && !chain[STAGES-1]));

endmodule

// File: rtl/chan_rotator.sv
module chan_rotator
  import rgb_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pix_fall,
  input  logic  smp_fall,
  input  logic  order_cfg,
  output chan_e sel
);
  logic order_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= CH_RED;
      order_q <= 1'b0;
    end else if (pix_fall) begin
      order_q <= order_cfg;
      sel     <= first_chan(order_cfg);
    end else if (smp_fall) begin
      sel     <= next_chan(sel, order_q);
    end
  end

  // R5 R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fall |=> (sel == ($past(order_cfg) ? CH_BLUE : CH_RED)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_fall && !smp_fall) |=> $stable(sel));

  // R3 R4
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_fall && !pix_fall) |=> (sel != $past(sel)));

  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'd3);

endmodule

// File: rtl/edge_guard.sv
module edge_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_fall,
  input  logic cnv_level,
  input  logic err_clr,
  output logic err
);
  logic hit;
  assign hit = sw_fall & cnv_level;

  always_ff @(posedge clk) begin
    if (!rst_n)       err <= 1'b0;
    else if (hit)     err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fall && cnv_level) |=> err);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

  // R8
  no_false_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err && !(sw_fall && cnv_level)) |=> !err);

endmodule

// File: rtl/rgb_seq_ctrl.sv
module rgb_seq_ctrl
  import rgb_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_clk_in,
  input  logic       smp_clk_in,
  input  logic       cnv_clk_in,
  input  logic       order_desc,
  input  logic       err_clr,
  output logic [1:0] chan_sel,
  output logic [2:0] chan_en,
  output logic       timing_err
);
  localparam int NUM_IN = 3;
  localparam int NUM_CH = 3;
  localparam int IDX_PIX = 0;
  localparam int IDX_SMP = 1;
  localparam int IDX_CNV = 2;

  logic [NUM_IN-1:0] raw_vec, lvl_vec, fall_vec;
  chan_e             sel;

  assign raw_vec = {cnv_clk_in, smp_clk_in, pix_clk_in};

  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
      edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_in(raw_vec[g]),
        .level (lvl_vec[g]),
        .fall  (fall_vec[g])
      );
    end
  endgenerate

  chan_rotator u_rot (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_fall (fall_vec[IDX_PIX]),
    .smp_fall (fall_vec[IDX_SMP]),
    .order_cfg(order_desc),
    .sel      (sel)
  );

  edge_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_fall  (fall_vec[IDX_SMP]),
    .cnv_level(lvl_vec[IDX_CNV]),
    .err_clr  (err_clr),
    .err      (timing_err)
  );

  assign chan_sel = sel;

  always_comb begin
    chan_en = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chan_sel == c[1:0]) chan_en[c] = 1'b1;
    end
  end

  // R1
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_en) == 1);

endmodule

// File: tb/sim_rgb_seq_ctrl.sv
module sim_rgb_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  typedef struct {
    logic [1:0] sel;
    logic       err;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix = 1'b1, smp = 1'b0, cnv = 1'b0, ord = 1'b0, clr = 1'b0;
  logic [1:0] chan_sel;
  logic [2:0] chan_en;
  logic       timing_err;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [1:0] m_sel = 2'd0;
  logic       m_ord = 1'b0;
  logic       m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_seq_ctrl #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_clk_in(pix), .smp_clk_in(smp),
    .cnv_clk_in(cnv), .order_desc(ord), .err_clr(clr),
    .chan_sel(chan_sel), .chan_en(chan_en), .timing_err(timing_err)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      exp_t it;
      wait (q.size() > 0);
      it = q.pop_front();
      chk(chan_sel == it.sel, {it.tag, " sel"}, chan_sel, it.sel);
      chk(chan_en == (3'b001 << it.sel), {it.tag, " en (R1)"}, chan_en, 3'b001 << it.sel);
      chk(timing_err == it.err, {it.tag, " err"}, timing_err, it.err);
    end
  end

  function automatic logic [1:0] m_next(input logic [1:0] s, input logic d);
    if (!d) return (s == 2'd2) ? 2'd0 : s + 2'd1;
    return (s == 2'd0) ? 2'd2 : s - 2'd1;
  endfunction

  task automatic push(input string tag);
    exp_t it;
    it.sel = m_sel; it.err = m_err; it.tag = tag;
    q.push_back(it);
    #1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_smp(input string tag);
    smp = 1'b1; wait_n(4);
    smp = 1'b0; wait_n(SYNC + 3);
    m_sel = m_next(m_sel, m_ord);
    if (cnv) m_err = 1'b1;
    push(tag);
  endtask

  task automatic restart_pix(input string tag);
    pix = 1'b1; wait_n(4);
    pix = 1'b0; wait_n(SYNC + 3);
    m_ord = ord;
    m_sel = ord ? 2'd2 : 2'd0;
    push(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(SYNC + 3);
    push("R2 reset");

    // R3 ascending with wrap
    step_smp("R3 R->G");
    step_smp("R3 G->B");
    step_smp("R3 B->R wrap");
    step_smp("R3 R->G again");
    pix = 1'b1; wait_n(4);
    restart_pix("R5 restart ascending");

    // R6 new order waits for the pixel strobe
    ord = 1'b1; wait_n(2);
    step_smp("R6 still ascending R->G");
    restart_pix("R5 restart descending to B");
    step_smp("R4 B->G");
    step_smp("R4 G->R");
    step_smp("R4 R->B wrap");

    // R11 exact latency: B -> G after SYNC+1 edges
    smp = 1'b1; wait_n(5);
    smp = 1'b0;
    wait_n(SYNC);
    chk(chan_sel == 2'd2, "R11 not before SYNC+1 edges", chan_sel, 2);
    wait_n(1);
    chk(chan_sel == 2'd1, "R11 at SYNC+1 edges", chan_sel, 1);
    m_sel = 2'd1;
    wait_n(4);

    // R7 simultaneous falls: restart wins
    pix = 1'b1; smp = 1'b1; wait_n(4);
    pix = 1'b0; smp = 1'b0; wait_n(SYNC + 3);
    m_sel = 2'd2; m_ord = 1'b1;
    push("R7 restart priority");

    // R10 sample-and-hold: smp stays low
    restart_pix("R10 hold B 1");
    restart_pix("R10 hold B 2");
    ord = 1'b0; wait_n(2);
    restart_pix("R10 order 0 gives R");
    restart_pix("R10 hold R");

    // R8 low converter clock leaves flag clear, high sets it
    step_smp("R8 step with cnv low");
    cnv = 1'b1; wait_n(4);
    step_smp("R8 step with cnv high");
    cnv = 1'b0; wait_n(6);
    push("R9 flag sticky");
    clr = 1'b1; wait_n(1); clr = 1'b0; wait_n(2);
    m_err = 1'b0;
    push("R9 flag cleared");

    wait_n(4);
    wait (q.size() == 0);
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule